// File: doc/BRIEF.md
# HDLC FIFO Status and Interrupt Unit

This block gathers the status of a packet link controller and presents it to a host as one 16-bit status word plus one interrupt line. The receive and transmit datapaths send it single-cycle event pulses: packet start, packet end, receive overrun, transmit underrun and transmit FIFO write. The two FIFOs also report their current byte occupancy. Framing, CRC checking and FIFO storage sit outside the block.

Event bits latch and stay set until the host reads the word, which it does by pulsing a read strobe. Level bits follow the FIFO counts in real time. An interrupt reaches the output only when the bit's own mask bit is set and the controller-wide mask bit is also set.

Top module: `hdlc_stat_irq`

## Requirements
- R1: A pulse on `rx_end_p` sets status bit 6. The pulse comes for every packet end, good or bad. The bit reads 1 from the cycle after the pulse.
- R2: A pulse on `rx_start_p` sets status bit 5. The bit reads 1 from the cycle after the pulse.
- R3: A pulse on `rx_ovr_p` sets status bit 13. The bit reads 1 from the cycle after the pulse.
- R4: A cycle with `rd_stb` high clears latched bits 13, 7, 6 and 5 from the next cycle on. The status word read during that cycle still shows them. A cleared bit stays 0 until its event recurs.
- R5: If an event pulse arrives in the same cycle as `rd_stb`, its bit is 1 in the next cycle.
- R6: Status bit 7 latches a `tx_undr_p` pulse only while the unit is armed. `tx_wr_p` arms the unit. A recorded underrun disarms it. The unit is disarmed after reset. If a write and an underrun pulse come in the same cycle, the unit stays armed.
- R7: Status bit 4 is 1 exactly when `rx_level` > 16 × (`wm_sel` + 1).
- R8: Status bits 11:8 equal floor(`tx_level` / 16), limited to 15.
- R9: Status bit 12 is 1 exactly when `tx_level` is 0.
- R10: `irq` = `ctrl_mask` AND (OR over bits 13, 7, 6, 5 and 4 of `status` & `irq_mask`). Bits 12 and 11:8 never drive `irq`. Bits 15, 14 and 3:0 read 0.
- R11: When the only enabled source is a latched bit, `irq` is low in the cycle after the read strobe that clears it.
- R12: After reset, all latched bits read 0 and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_start_p | input | 1 | Packet opening byte seen |
| rx_end_p | input | 1 | Packet finished (any cause) |
| rx_ovr_p | input | 1 | Receive FIFO overran |
| tx_undr_p | input | 1 | Transmit FIFO ran dry, abort sent |
| tx_wr_p | input | 1 | Byte written to transmit FIFO |
| tx_level | input | 9 | Transmit FIFO byte count |
| rx_level | input | 9 | Receive FIFO byte count |
| wm_sel | input | 3 | Receive watermark setting |
| irq_mask | input | 16 | Per-bit interrupt enables |
| ctrl_mask | input | 1 | Controller-wide interrupt enable |
| rd_stb | input | 1 | Host reads the status word |
| status | output | 16 | Status word |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check on every cycle that each event pulse appears in its latched bit on the next cycle, even when a read coincides with it. They also check that a read with no new event clears the bit, that `irq` stays low without the controller-wide mask, and that `irq` always has an enabled source behind it. They check that a nonzero level code never appears alongside the empty flag. Only the bench scenarios can show the underrun arming sequence, since that needs a write, an underrun, a read and a second underrun in order. The same holds for the exact level-code and watermark boundaries across FIFO counts and for the timing of `irq` falling after a read.

// File: rtl/hdlc_stat_irq.sv
module hdlc_stat_irq #(
  parameter int LVL_W   = 9,
  parameter int STEP_LG = 4,
  parameter int WM_W    = 3,
  parameter int CODE_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_start_p,
  input  logic              rx_end_p,
  input  logic              rx_ovr_p,
  input  logic              tx_undr_p,
  input  logic              tx_wr_p,
  input  logic [LVL_W-1:0]  tx_level,
  input  logic [LVL_W-1:0]  rx_level,
  input  logic [WM_W-1:0]   wm_sel,
  input  logic [15:0]       irq_mask,
  input  logic              ctrl_mask,
  input  logic              rd_stb,
  output logic [15:0]       status,
  output logic              irq
);
  localparam logic [15:0] IRQ_SRC  = 16'h20F0;
  localparam int          THR_W    = LVL_W + 1;
  localparam logic [CODE_W-1:0] CODE_MAX = '1;

  logic lat_ovr, lat_und, lat_end, lat_start, armed;
  logic [LVL_W-1:0]  steps;
  logic [CODE_W-1:0] code;
  logic [THR_W-1:0]  thr;
  logic              hwm;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lat_ovr   <= 1'b0;
      lat_und   <= 1'b0;
      lat_end   <= 1'b0;
      lat_start <= 1'b0;
      armed     <= 1'b0;
    end else begin
      lat_ovr   <= rx_ovr_p   | (lat_ovr   & ~rd_stb);
      lat_end   <= rx_end_p   | (lat_end   & ~rd_stb);
      lat_start <= rx_start_p | (lat_start & ~rd_stb);
      lat_und   <= (tx_undr_p & armed) | (lat_und & ~rd_stb);
      armed     <= tx_wr_p | (armed & ~tx_undr_p);
    end
  end

  assign steps = tx_level >> STEP_LG;
  assign code  = (steps > LVL_W'(CODE_MAX)) ? CODE_MAX : steps[CODE_W-1:0];
  assign thr   = (THR_W'(wm_sel) + THR_W'(1)) << STEP_LG;
  assign hwm   = THR_W'(rx_level) > thr;

  assign status = {2'b00, lat_ovr, (tx_level == '0), code,
                   lat_und, lat_end, lat_start, hwm, 4'b0000};
  assign irq    = ctrl_mask & |(status & irq_mask & IRQ_SRC);
endmodule

// File: rtl/hdlc_stat_irq_chk.sv
module hdlc_stat_irq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        rx_start_p,
  input logic        rx_end_p,
  input logic        rx_ovr_p,
  input logic        rd_stb,
  input logic [15:0] irq_mask,
  input logic        ctrl_mask,
  input logic [15:0] status,
  input logic        irq
);
  p_end_sets_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rx_end_p |=> status[6]);
  p_start_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rx_start_p |=> status[5]);
  p_ovr_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ovr_p |=> status[13]);
  p_read_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !rx_end_p) |=> !status[6]);
  p_collide_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && rx_start_p) |=> status[5]);
  p_empty_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
    status[12] |-> (status[11:8] == 4'd0));
  p_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_mask |-> !irq);
  p_source_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> |(status & irq_mask & 16'h20F0));
endmodule

bind hdlc_stat_irq hdlc_stat_irq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rx_start_p(rx_start_p), .rx_end_p(rx_end_p),
  .rx_ovr_p(rx_ovr_p), .rd_stb(rd_stb), .irq_mask(irq_mask),
  .ctrl_mask(ctrl_mask), .status(status), .irq(irq)
);

// File: tb/hdlc_stat_irq_test.sv
`timescale 1ns/1ps
module hdlc_stat_irq_test;
  logic clk = 0, rst_n = 0;
  logic rx_start_p = 0, rx_end_p = 0, rx_ovr_p = 0, tx_undr_p = 0, tx_wr_p = 0;
  logic [8:0] tx_level = 0, rx_level = 0;
  logic [2:0] wm_sel = 0;
  logic [15:0] irq_mask = 0;
  logic ctrl_mask = 0, rd_stb = 0;
  logic [15:0] status;
  logic irq;

  int checks = 0, fails = 0;
  bit m_ovr, m_und, m_end, m_start, m_arm;

  always #10 clk = ~clk;

  hdlc_stat_irq uut (.*);

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic compare();
    int code, thr, src;
    bit e_irq;
    code = tx_level / 16; if (code > 15) code = 15;
    thr = 16 * (wm_sel + 1);
    chk("R1 bit6", status[6], m_end);
    chk("R2 bit5", status[5], m_start);
    chk("R3 bit13", status[13], m_ovr);
    chk("R6 bit7", status[7], m_und);
    chk("R7 bit4", status[4], rx_level > thr);
    chk("R8 code", status[11:8], code);
    chk("R9 bit12", status[12], tx_level == 0);
    chk("R10 unused", {status[15:14], status[3:0]}, 0);
    src = (m_ovr & irq_mask[13]) | (m_und & irq_mask[7]) | (m_end & irq_mask[6])
        | (m_start & irq_mask[5]) | ((rx_level > thr) & irq_mask[4]);
    e_irq = ctrl_mask && src != 0;
    chk("R10 irq", irq, e_irq);
  endtask

  // inputs are set by caller after a negedge; compare, then advance one edge
  task automatic step();
    #1 compare();
    @(posedge clk);
    if (rst_n) begin
      m_ovr   = rx_ovr_p   | (m_ovr   & !rd_stb);
      m_end   = rx_end_p   | (m_end   & !rd_stb);
      m_start = rx_start_p | (m_start & !rd_stb);
      m_und   = (tx_undr_p & m_arm) | (m_und & !rd_stb);
      if (tx_wr_p) m_arm = 1; else if (tx_undr_p) m_arm = 0;
    end
    @(negedge clk);
    {rx_start_p, rx_end_p, rx_ovr_p, tx_undr_p, tx_wr_p, rd_stb} = '0;
  endtask

  initial begin
    #3_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R12 reset state
    chk("R12 status", status & 16'h20E0, 0);
    chk("R12 irq", irq, 0);
    irq_mask = 16'hFFFF; ctrl_mask = 1;
    // R1 and R11
    rx_end_p = 1; step();
    chk("R1 end latched", status[6], 1);
    chk("R10 irq up", irq, 1);
    rd_stb = 1; step();
    chk("R4 cleared", status[6], 0);
    chk("R11 irq fell", irq, 0);
    // R5 collision
    rx_start_p = 1; step();
    rx_start_p = 1; rd_stb = 1; step();
    chk("R5 kept", status[5], 1);
    rd_stb = 1; step();
    chk("R4 start cleared", status[5], 0);
    // R3
    rx_ovr_p = 1; step();
    chk("R3 ovr", status[13], 1);
    ctrl_mask = 0; step();
    chk("R10 global gate", irq, 0);
    ctrl_mask = 1; irq_mask = 16'h0000; step();
    chk("R10 bit gate", irq, 0);
    irq_mask = 16'hFFFF; rd_stb = 1; step();
    // R6 arming
    tx_undr_p = 1; step();
    chk("R6 disarmed at reset", status[7], 0);
    tx_wr_p = 1; step();
    tx_undr_p = 1; step();
    chk("R6 armed set", status[7], 1);
    rd_stb = 1; step();
    tx_undr_p = 1; step();
    chk("R6 not rearmed", status[7], 0);
    tx_wr_p = 1; step();
    tx_undr_p = 1; step();
    chk("R6 rearmed", status[7], 1);
    rd_stb = 1; step();
    // R7 / R8 / R9 boundaries; level bits must not raise irq
    irq_mask = 16'h1F00;
    wm_sel = 3'd2; rx_level = 9'd48; tx_level = 9'd0; step();
    chk("R7 at threshold", status[4], 0);
    chk("R10 level no irq", irq, 0);
    rx_level = 9'd49; tx_level = 9'd15; step();
    chk("R7 above", status[4], 1);
    chk("R8 15 bytes", status[11:8], 0);
    tx_level = 9'd16; step();
    chk("R8 16 bytes", status[11:8], 1);
    tx_level = 9'd256; step();
    chk("R8 256 bytes", status[11:8], 15);
    chk("R9 not empty", status[12], 0);
    wm_sel = 3'd7; rx_level = 9'd128; step();
    chk("R7 max threshold", status[4], 0);
    irq_mask = 16'hFFFF;
    // random phase against the model
    for (int i = 0; i < 4000; i++) begin
      rx_start_p = ($urandom % 8) == 0;
      rx_end_p   = ($urandom % 8) == 0;
      rx_ovr_p   = ($urandom % 16) == 0;
      tx_undr_p  = ($urandom % 6) == 0;
      tx_wr_p    = ($urandom % 6) == 0;
      rd_stb     = ($urandom % 4) == 0;
      tx_level   = 9'($urandom % 257);
      rx_level   = 9'($urandom % 257);
      wm_sel     = 3'($urandom);
      irq_mask   = 16'($urandom);
      ctrl_mask  = ($urandom % 4) != 0;
      step();
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule